// File: doc/BRIEF.md
# Multi-Channel Capture Timer with Interrupt Vector

This block is a free-running counter with several capture channels, reached through a simple word-wide register bus. Each channel watches one input pin. It synchronises the pin to the timer clock and looks for the edge polarity that software selected. When that edge arrives, the channel copies the current counter value into its capture register and raises a pending flag. A system uses it to timestamp external events, for example to measure the period or frequency of sensor signals.

Channel 0 owns a dedicated interrupt line. Its flag clears when the interrupt controller returns a one-cycle acknowledge. The other channels and the counter-wrap event share a second interrupt line. A handler on the shared line reads the vector register, which returns a small even code for the highest-priority pending source that is enabled. That read also clears the flag of the source it named. Software can add the code to its program counter to jump straight into a table of handlers. A wrap that is pending and enabled but never serviced stays at the bottom of that priority order. Because the register decodes only one source per read, handlers must service every code.

The counter has two modes. In stop mode it holds its value. In continuous mode it advances on every cycle in which the clock-enable input is high, and it wraps from all-ones to zero.

Top module: `capTimer`

## Requirements
- R1: After reset the counter reads 0, every flag and capture-overflow bit reads 0, the vector register reads 0x0000, and both interrupt outputs are low.
- R2: With the run bit (timer control bit 0) clear, the counter holds its value. With the run bit set, the counter advances by one on each clock in which `tickEn` is high. A write to the count register (address 1) loads the counter. A step from 0xFFFF to 0x0000 sets the wrap flag (status bit 3).
- R3: Each channel control register (addresses 2..4, bits [1:0]) selects the edge: 0 = none, 1 = rising, 2 = falling, 3 = both. A selected edge copies the counter into the channel's capture register (addresses 5..7) and sets the channel flag (status bit n). An edge that is not selected changes neither.
- R4: A channel flag is set on a capture whether or not that channel's interrupt enable (channel control bit 3) is set. Only the interrupt outputs are gated by the enable.
- R5: `irqCh0` is high while the channel 0 flag and its enable are both set. A one-cycle `irqAck0` pulse clears the channel 0 flag.
- R6: `irqShared` is high while any of the channel 1 flag, the channel 2 flag or the wrap flag is set together with its own enable. The wrap enable is timer control bit 1.
- R7: The vector register (address 9) returns 0x0002 for channel 1, 0x0004 for channel 2 and 0x000E for wrap. The first source in that order that is both pending and enabled wins. The register returns 0x0000 when no such source exists.
- R8: Reading the vector register clears only the flag of the source that it returns.
- R9: Writing a channel control register never clears a pending flag. In a write to the status register (address 8), a 0 in a bit position clears that flag and a 1 leaves it unchanged.
- R10: A capture on a channel whose flag is still set sets that channel's capture-overflow bit (status bit 4+n). The capture register takes the new value.
- R11: Setting a channel's synchronous-capture bit (channel control bit 2) adds exactly one timer clock of latency between the pin edge and the capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count enable for continuous mode |
| capPin | input | 3 | Asynchronous capture inputs, one per channel |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (vector read clears a source) |
| busAddr | input | 4 | Register word address |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data, valid in the cycle of the read strobe |
| irqAck0 | input | 1 | One-cycle acknowledge of the channel 0 interrupt |
| irqCh0 | output | 1 | Dedicated channel 0 interrupt |
| irqShared | output | 1 | Shared interrupt for channels 1, 2 and wrap |

## Verification
The hardest case to reach is one where channel 1, channel 2 and the wrap flag are all pending at the same moment. Only then does the vector's priority order and its clear-one-source-per-read behaviour show. The bench first loads the counter just below all-ones and runs it briefly so that it wraps. It then raises both channel pins together and drains the vector register one read at a time. A second run of that sequence leaves the wrap enable off, to show that a pending but disabled source stays out of the vector. The one-cycle cost of the synchronous-capture bit is measured by raising two pins in the same cycle while the counter runs. One pin's channel has the extra stage and the other's does not, so the two capture values must differ by exactly one.

// File: rtl/capTimerPkg.sv
package capTimerPkg;
  parameter int CNT_W  = 16;
  parameter int NUM_CH = 3;
  parameter int ADDR_W = 4;

  localparam int ADDR_TCTL   = 0;
  localparam int ADDR_COUNT  = 1;
  localparam int ADDR_CHCTL0 = 2;
  localparam int ADDR_CAP0   = ADDR_CHCTL0 + NUM_CH;
  localparam int ADDR_STAT   = ADDR_CAP0 + NUM_CH;
  localparam int ADDR_VEC    = ADDR_STAT + 1;
  localparam int STAT_OVF    = NUM_CH;
  localparam int STAT_COV0   = NUM_CH + 1;
  localparam logic [CNT_W-1:0] VEC_WRAP = CNT_W'(14);

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edgeMode_e;

  typedef struct packed {
    logic                        run;
    logic                        cntLoad;
    logic [CNT_W-1:0]            cntLoadVal;
    logic [NUM_CH-1:0][1:0]      edgeMode;
    logic [NUM_CH-1:0]           syncSel;
  } dpStrobe_t;
endpackage

// File: rtl/capTimerDatapath.sv
module capTimerDatapath
  import capTimerPkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         tickEn,
  input  logic [NUM_CH-1:0]            capPin,
  input  dpStrobe_t                    strobe,
  output logic [CNT_W-1:0]             count,
  output logic [NUM_CH-1:0][CNT_W-1:0] capValue,
  output logic [NUM_CH-1:0]            capEvent,
  output logic                         wrapPulse
);
  logic stepNow;
  assign stepNow   = strobe.run && tickEn && !strobe.cntLoad;
  assign wrapPulse = stepNow && (count == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rstN)               count <= '0;
    else if (strobe.cntLoad) count <= strobe.cntLoadVal;
    else if (stepNow)        count <= count + 1'b1;
  end

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    stepNow |=> count == CNT_W'($past(count) + 1'b1));
  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.cntLoad) |=> count == $past(count));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic syncA, syncB, syncC, prevLvl, lvl, rise, fall;
    edgeMode_e mode;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncA   <= 1'b0;
        syncB   <= 1'b0;
        syncC   <= 1'b0;
        prevLvl <= 1'b0;
      end else begin
        syncA   <= capPin[ch];
        syncB   <= syncA;
        syncC   <= syncB;
        prevLvl <= lvl;
      end
    end

    assign lvl  = strobe.syncSel[ch] ? syncC : syncB;
    assign rise = lvl && !prevLvl;
    assign fall = !lvl && prevLvl;
    assign mode = edgeMode_e'(strobe.edgeMode[ch]);

    always_comb begin
      unique case (mode)
        EDGE_RISE: capEvent[ch] = rise;
        EDGE_FALL: capEvent[ch] = fall;
        EDGE_BOTH: capEvent[ch] = rise || fall;
        default:   capEvent[ch] = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN)             capValue[ch] <= '0;
      else if (capEvent[ch]) capValue[ch] <= count;
    end

    p_cap_latch_r3: assert property (@(posedge clk) disable iff (!rstN)
      capEvent[ch] |=> capValue[ch] == $past(count));
  end
endmodule

// File: rtl/capTimerCtrl.sv
module capTimerCtrl
  import capTimerPkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         busWrEn,
  input  logic                         busRdEn,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [CNT_W-1:0]             busWrData,
  output logic [CNT_W-1:0]             busRdData,
  input  logic                         irqAck0,
  input  logic [CNT_W-1:0]             count,
  input  logic [NUM_CH-1:0][CNT_W-1:0] capValue,
  input  logic [NUM_CH-1:0]            capEvent,
  input  logic                         wrapPulse,
  output dpStrobe_t                    strobe,
  output logic                         irqCh0,
  output logic                         irqShared
);
  logic                   runBit, wrapIe, wrapFlag;
  logic [NUM_CH-1:0][1:0] chEdge;
  logic [NUM_CH-1:0]      chSync, chIe, chFlag, capOvf;

  logic wrTctl, wrStat, vecRead;
  assign wrTctl  = busWrEn && (busAddr == ADDR_W'(ADDR_TCTL));
  assign wrStat  = busWrEn && (busAddr == ADDR_W'(ADDR_STAT));
  assign vecRead = busRdEn && (busAddr == ADDR_W'(ADDR_VEC));

  // strobes to the datapath
  always_comb begin
    strobe.run        = runBit;
    strobe.cntLoad    = busWrEn && (busAddr == ADDR_W'(ADDR_COUNT));
    strobe.cntLoadVal = busWrData;
    strobe.edgeMode   = chEdge;
    strobe.syncSel    = chSync;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit <= 1'b0;
      wrapIe <= 1'b0;
    end else if (wrTctl) begin
      runBit <= busWrData[0];
      wrapIe <= busWrData[1];
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chEdge[ch] <= 2'b00;
        chSync[ch] <= 1'b0;
        chIe[ch]   <= 1'b0;
      end else if (busWrEn && busAddr == ADDR_W'(ADDR_CHCTL0 + ch)) begin
        chEdge[ch] <= busWrData[1:0];
        chSync[ch] <= busWrData[2];
        chIe[ch]   <= busWrData[3];
      end
    end
  end

  // prioritised vector: lowest shared channel first, wrap last
  logic [CNT_W-1:0]  vecCode;
  logic [NUM_CH-1:0] vecHitCh;
  logic              vecHitWrap;
  always_comb begin
    logic found;
    found      = 1'b0;
    vecCode    = '0;
    vecHitCh   = '0;
    vecHitWrap = 1'b0;
    for (int k = 1; k < NUM_CH; k++) begin
      if (!found && chFlag[k] && chIe[k]) begin
        found       = 1'b1;
        vecHitCh[k] = 1'b1;
        vecCode     = CNT_W'(2 * k);
      end
    end
    if (!found && wrapFlag && wrapIe) begin
      vecHitWrap = 1'b1;
      vecCode    = VEC_WRAP;
    end
  end

  // flag clears gathered from every source
  logic [NUM_CH-1:0] clrCh, clrCov;
  logic              clrWrap;
  always_comb begin
    clrCh   = wrStat ? ~busWrData[NUM_CH-1:0] : '0;
    clrCov  = wrStat ? ~busWrData[STAT_COV0 +: NUM_CH] : '0;
    clrWrap = (wrStat && !busWrData[STAT_OVF]) || (vecRead && vecHitWrap);
    if (vecRead) clrCh = clrCh | vecHitCh;
    if (irqAck0) clrCh[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chFlag   <= '0;
      capOvf   <= '0;
      wrapFlag <= 1'b0;
    end else begin
      chFlag   <= (chFlag & ~clrCh) | capEvent;
      capOvf   <= (capOvf & ~clrCov) | (capEvent & chFlag);
      wrapFlag <= (wrapFlag && !clrWrap) || wrapPulse;
    end
  end

  logic [NUM_CH-1:1] sharedReq;
  assign sharedReq = chFlag[NUM_CH-1:1] & chIe[NUM_CH-1:1];
  assign irqCh0    = chFlag[0] && chIe[0];
  assign irqShared = (|sharedReq) || (wrapFlag && wrapIe);

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(ADDR_TCTL))  busRdData = CNT_W'({wrapIe, runBit});
    if (busAddr == ADDR_W'(ADDR_COUNT)) busRdData = count;
    for (int k = 0; k < NUM_CH; k++) begin
      if (busAddr == ADDR_W'(ADDR_CHCTL0 + k))
        busRdData = CNT_W'({chIe[k], chSync[k], chEdge[k]});
      if (busAddr == ADDR_W'(ADDR_CAP0 + k)) busRdData = capValue[k];
    end
    if (busAddr == ADDR_W'(ADDR_STAT)) busRdData = CNT_W'({capOvf, wrapFlag, chFlag});
    if (busAddr == ADDR_W'(ADDR_VEC))  busRdData = vecCode;
  end

  p_wrap_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |=> wrapFlag);
  p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck0 && !capEvent[0]) |=> !chFlag[0]);
  p_vec_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    (vecCode == '0) || (vecCode == VEC_WRAP) || (vecCode[0] == 1'b0 && vecCode < CNT_W'(2 * NUM_CH)));
  p_vec_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    (vecCode == '0) |-> !irqShared);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rstN)
      capEvent[ch] |=> chFlag[ch]);
    p_cap_ovf_r10: assert property (@(posedge clk) disable iff (!rstN)
      (capEvent[ch] && chFlag[ch]) |=> capOvf[ch]);
    if (ch > 0) begin : g_vec
      p_vec_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
        (vecRead && vecCode == CNT_W'(2 * ch) && !capEvent[ch]) |=> !chFlag[ch]);
    end
  end
endmodule

// File: rtl/capTimer.sv
module capTimer
  import capTimerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [NUM_CH-1:0] capPin,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [CNT_W-1:0]  busRdData,
  input  logic              irqAck0,
  output logic              irqCh0,
  output logic              irqShared
);
  dpStrobe_t                    strobe;
  logic [CNT_W-1:0]             count;
  logic [NUM_CH-1:0][CNT_W-1:0] capValue;
  logic [NUM_CH-1:0]            capEvent;
  logic                         wrapPulse;

  capTimerCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqAck0(irqAck0), .count(count), .capValue(capValue),
    .capEvent(capEvent), .wrapPulse(wrapPulse), .strobe(strobe),
    .irqCh0(irqCh0), .irqShared(irqShared)
  );

  capTimerDatapath i_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .capPin(capPin),
    .strobe(strobe), .count(count), .capValue(capValue),
    .capEvent(capEvent), .wrapPulse(wrapPulse)
  );
endmodule

// File: tb/test_capTimer.sv
`timescale 1ns/1ps
module test_capTimer;
  logic        clk = 1'b0, rstN = 1'b0, tickEn = 1'b0;
  logic [2:0]  capPin = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0, irqAck0 = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        irqCh0, irqShared;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  capTimer i_capTimer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .capPin(capPin),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqAck0(irqAck0),
    .irqCh0(irqCh0), .irqShared(irqShared)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk); #1 busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    @(posedge clk); #1 busRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setPin(input int ch, input logic v);
    @(negedge clk); capPin[ch] = v;
  endtask

  typedef struct packed {
    logic [1:0]  edgeSel;
    logic        fromLvl;
    logic        toLvl;
    logic        expFlag;
    logic [15:0] cntVal;
  } vec_t;

  localparam vec_t TABLE [7] = '{
    '{2'd1, 1'b0, 1'b1, 1'b1, 16'h1111},
    '{2'd1, 1'b1, 1'b0, 1'b0, 16'h2222},
    '{2'd2, 1'b1, 1'b0, 1'b1, 16'h3333},
    '{2'd2, 1'b0, 1'b1, 1'b0, 16'h4444},
    '{2'd3, 1'b0, 1'b1, 1'b1, 16'h5555},
    '{2'd3, 1'b1, 1'b0, 1'b1, 16'h6666},
    '{2'd0, 1'b0, 1'b1, 1'b0, 16'h7777}
  };

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, d2;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    rd(4'd1, d); check("R1 count", d, 16'h0000);
    rd(4'd8, d); check("R1 status", d, 16'h0000);
    rd(4'd9, d); check("R1 vector", d, 16'h0000);
    check("R1 irqCh0", {15'd0, irqCh0}, 16'd0);
    check("R1 irqShared", {15'd0, irqShared}, 16'd0);

    // R3 edge selection table on channel 0, counter stopped
    foreach (TABLE[i]) begin
      wr(4'd2, 16'h0000);
      setPin(0, TABLE[i].fromLvl);
      idle(6);
      wr(4'd8, 16'h0000);
      wr(4'd5 - 4'd3, {14'd0, TABLE[i].edgeSel});
      wr(4'd1, TABLE[i].cntVal);
      setPin(0, TABLE[i].toLvl);
      idle(6);
      rd(4'd8, d);
      check("R3 flag", {15'd0, d[0]}, {15'd0, TABLE[i].expFlag});
      if (TABLE[i].expFlag) begin
        rd(4'd5, d); check("R3 capture", d, TABLE[i].cntVal);
      end
    end
    wr(4'd2, 16'h0000);
    setPin(0, 1'b0);
    idle(6);
    wr(4'd8, 16'h0000);

    // R2 stop / run / tickEn
    wr(4'd1, 16'h0010);
    idle(4);
    rd(4'd1, d); check("R2 stop holds", d, 16'h0010);
    wr(4'd0, 16'h0001);
    rd(4'd1, d); rd(4'd1, d2);
    check("R2 tickEn low holds", d2, d);
    tickEn = 1'b1;
    rd(4'd1, d); rd(4'd1, d2);
    check("R2 advance per tick", d2 - d, 16'd1);
    wr(4'd0, 16'h0000);

    // R2 wrap, R6/R7/R8 shared vector
    wr(4'd1, 16'hFFFD);
    wr(4'd0, 16'h0003);
    idle(6);
    wr(4'd0, 16'h0002);
    rd(4'd8, d); check("R2 wrap flag", {15'd0, d[3]}, 16'd1);
    wr(4'd3, 16'h0009);
    wr(4'd4, 16'h0009);
    @(negedge clk); capPin[1] = 1'b1; capPin[2] = 1'b1;
    idle(6);
    check("R6 shared irq", {15'd0, irqShared}, 16'd1);
    rd(4'd9, d); check("R7 first ch1", d, 16'h0002);
    rd(4'd9, d); check("R7 then ch2", d, 16'h0004);
    rd(4'd8, d); check("R8 wrap still pending", {15'd0, d[3]}, 16'd1);
    rd(4'd9, d); check("R7 then wrap", d, 16'h000E);
    rd(4'd9, d); check("R7 empty", d, 16'h0000);
    check("R6 shared low", {15'd0, irqShared}, 16'd0);

    // R7 disabled wrap stays out of vector
    wr(4'd1, 16'hFFFE);
    wr(4'd0, 16'h0001);
    idle(5);
    wr(4'd0, 16'h0000);
    rd(4'd9, d); check("R7 disabled wrap", d, 16'h0000);
    check("R6 disabled wrap no irq", {15'd0, irqShared}, 16'd0);
    rd(4'd8, d); check("R7 wrap flag kept", {15'd0, d[3]}, 16'd1);

    // R9 status write: 1 keeps, 0 clears
    wr(4'd8, 16'hFFFF);
    rd(4'd8, d); check("R9 write one keeps", {15'd0, d[3]}, 16'd1);
    wr(4'd8, 16'h0000);
    rd(4'd8, d); check("R9 write zero clears", d, 16'h0000);

    // R4 flag without enable, R9 control write keeps flag
    wr(4'd3, 16'h0001);
    setPin(1, 1'b0); idle(6);
    wr(4'd8, 16'h0000);
    setPin(1, 1'b1); idle(6);
    rd(4'd8, d); check("R4 flag set unenabled", {15'd0, d[1]}, 16'd1);
    check("R4 irq gated", {15'd0, irqShared}, 16'd0);
    rd(4'd9, d); check("R4 vector ignores unenabled", d, 16'h0000);
    wr(4'd3, 16'h0009);
    rd(4'd8, d); check("R9 ctrl write keeps flag", {15'd0, d[1]}, 16'd1);
    check("R4 irq after enable", {15'd0, irqShared}, 16'd1);
    wr(4'd8, 16'h0000);

    // R5 channel 0 dedicated irq and acknowledge
    wr(4'd2, 16'h0009);
    wr(4'd1, 16'h0100);
    setPin(0, 1'b1); idle(6);
    check("R5 irqCh0 high", {15'd0, irqCh0}, 16'd1);
    check("R5 shared untouched", {15'd0, irqShared}, 16'd0);
    @(negedge clk); irqAck0 = 1'b1;
    @(negedge clk); irqAck0 = 1'b0;
    check("R5 irqCh0 after ack", {15'd0, irqCh0}, 16'd0);
    rd(4'd8, d); check("R5 flag cleared by ack", {15'd0, d[0]}, 16'd0);

    // R10 capture overflow
    setPin(0, 1'b0); idle(6);
    setPin(0, 1'b1); idle(6);
    setPin(0, 1'b0); idle(6);
    wr(4'd1, 16'h0200);
    setPin(0, 1'b1); idle(6);
    rd(4'd8, d); check("R10 overflow bit", {15'd0, d[4]}, 16'd1);
    rd(4'd5, d); check("R10 newest value", d, 16'h0200);
    wr(4'd8, 16'h0000);

    // R11 synchronous-capture latency
    wr(4'd3, 16'h0001);
    wr(4'd4, 16'h0005);
    @(negedge clk); capPin[1] = 1'b0; capPin[2] = 1'b0;
    idle(6);
    wr(4'd8, 16'h0000);
    wr(4'd0, 16'h0001);
    @(negedge clk); capPin[1] = 1'b1; capPin[2] = 1'b1;
    idle(8);
    wr(4'd0, 16'h0000);
    rd(4'd6, d); rd(4'd7, d2);
    check("R11 one extra cycle", d2 - d, 16'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule